// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a processor read an external serial NOR flash as if it were ordinary memory. Software first stores a read-command template, which holds an opcode, an address length, a data-lane format and a count of dummy bytes. Once a valid template is stored, the engine is initialized, and every 32-bit read on the window port becomes one serial flash transaction. The transaction sends the opcode, then the byte offset of the access, then the dummy bytes. It then collects four data bytes and returns them as a little-endian word. A reset write takes the engine out of memory mode, so that a command sequencer can use the same flash.

The serial side runs in clock mode 0. SCK idles low, data is launched while SCK is low, and data is sampled on the rising edge of SCK. One SCK period takes two system clocks. The sequencing state machine has six states. It waits in `ST_IDLE`. It moves to `ST_OPCODE` on a window request when initialized. On a window request when not initialized, it moves to `ST_RESP`. From `ST_OPCODE` it goes to `ST_ADDR`. From `ST_ADDR` it goes to `ST_DUMMY` if the dummy count is non-zero, and to `ST_DATA` otherwise. `ST_DUMMY` goes to `ST_DATA`. `ST_DATA` goes to `ST_RESP` after the fourth byte. `ST_RESP` always returns to `ST_IDLE`. Each read works from a copy of the template taken when the read starts.

Top module: `mfr_read_engine`

## Requirements
- R1: After reset, `stat_init` is 0, `spi_cs_n` is 1, `spi_sck` is 0 and `win_ready` is 0. SCK stays low whenever chip select is high.
- R2: The template word holds the opcode in bits 31:24, the frame code in bits 23:21, the field format in bits 20:19 and the dummy byte count in bits 18:16. Writing a template whose frame code is 2 to 5 stores it and sets `stat_init` in the next cycle. The number of address bytes is the frame code minus one.
- R3: A template write with a frame code of 0, 1, 6 or 7 is rejected. `stat_init` is unchanged, and later reads still use the previously stored template.
- R4: A pulse on `rst_wr` clears `stat_init` in the next cycle. It takes precedence over a template write in the same cycle, which is then not stored.
- R5: A window read while `stat_init` is 0 gets a one-cycle `win_ready` with `win_err` set, and it produces no chip-select or SCK activity.
- R6: An initialized read sends the template opcode on `spi_io_o[0]` first, most significant bit first, with chip select held low for the whole transaction.
- R7: The address bytes follow the opcode, most significant first. They carry `win_addr`, zero-extended and truncated to the configured number of address bytes.
- R8: Between the address and the data there are exactly 8 × (dummy byte count) SCK rising edges.
- R9: A field format of 1 reads data on 2 lanes (`spi_io_i[1:0]`) when `dual_sel` is 1, and on 4 lanes (`spi_io_i[3:0]`) when it is 0. On each edge the highest lane carries the most significant bit. Any other field format reads data serially on `spi_io_i[1]`.
- R10: The four data bytes go into `win_rdata` little-endian, with the first byte in bits 7:0. `win_ready` is a single-cycle pulse raised only after the last byte, with chip select already high.
- R11: During the opcode, address and dummy bytes only `spi_io_oe[0]` is set. During data bytes no output enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmpl_wr | input | 1 | Template register write strobe |
| tmpl_wdata | input | 32 | Template word |
| rst_wr | input | 1 | Leave memory mode (reset bit write) |
| dual_sel | input | 1 | For multi-lane reads: 1 selects 2 lanes, 0 selects 4 lanes |
| win_req | input | 1 | Window read request, held until `win_ready` |
| win_addr | input | ADDR_W | Byte offset of the read within the window |
| win_ready | output | 1 | Read response strobe |
| win_err | output | 1 | Error response, valid with `win_ready` |
| win_rdata | output | BUS_W | Read data, valid with `win_ready` |
| stat_init | output | 1 | Memory mode initialized |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_io_o | output | 4 | Serial data out |
| spi_io_oe | output | 4 | Serial data output enables |
| spi_io_i | input | 4 | Serial data in |

## Verification
The bench drives a behavioural flash model that records the opcode and address bits it receives and counts every SCK rising edge. Several corner cases get their own test:
- Reads before initialization and after a reset write must return an error with zero SCK edges. A design that forgot the init check would clock the flash.
- A 4-byte address with a 24-bit offset must send a zero top byte.
- A 2-byte address must drop the top byte of the offset.
- A design that used the wrong dummy count, or the wrong lane count in dual or quad mode, would show a different edge total and scrambled data.
- A rejected template, and a reset write colliding with a template write, must leave the earlier state in force.

// File: rtl/mfr_pkg.sv
package mfr_pkg;

    typedef struct packed {
        logic [7:0] opcode;
        logic [2:0] frame;
        logic [1:0] field;
        logic [2:0] inter;
    } tmpl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_RESP
    } st_t;

    localparam logic [1:0] LANE_1 = 2'd0;
    localparam logic [1:0] LANE_2 = 2'd1;
    localparam logic [1:0] LANE_4 = 2'd2;

    function automatic tmpl_t tmpl_unpack(input logic [31:0] w);
        tmpl_t t;
        t.opcode = w[31:24];
        t.frame  = w[23:21];
        t.field  = w[20:19];
        t.inter  = w[18:16];
        return t;
    endfunction

    function automatic logic frame_ok(input logic [2:0] f);
        return (f >= 3'd2) && (f <= 3'd5);
    endfunction

endpackage

// File: rtl/mfr_tmpl.sv
module mfr_tmpl
    import mfr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tmpl_wr,
    input  logic [31:0] tmpl_wdata,
    input  logic        rst_wr,
    output tmpl_t       tmpl,
    output logic        init
);
    tmpl_t cand;
    assign cand = tmpl_unpack(tmpl_wdata);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmpl <= '0;
            init <= 1'b0;
        end else if (rst_wr) begin
            init <= 1'b0;
        end else if (tmpl_wr && frame_ok(cand.frame)) begin
            tmpl <= cand;
            init <= 1'b1;
        end
    end
endmodule

// File: rtl/mfr_shift.sv
module mfr_shift
    import mfr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [1:0] lw,
    input  logic [7:0] tx,
    input  logic [3:0] io_i,
    output logic       sck,
    output logic       tx_bit,
    output logic [7:0] rx,
    output logic       done
);
    logic       active;
    logic       phase;
    logic [2:0] cnt;
    logic [7:0] sh;

    assign sck    = active & phase;
    assign tx_bit = sh[7];
    assign done   = active & phase & (cnt == 3'd0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            phase  <= 1'b0;
            cnt    <= '0;
            sh     <= '0;
            rx     <= '0;
        end else if (!active) begin
            if (go) begin
                active <= 1'b1;
                phase  <= 1'b0;
                sh     <= tx;
                cnt    <= (lw == LANE_4) ? 3'd1 : (lw == LANE_2) ? 3'd3 : 3'd7;
            end
        end else if (!phase) begin
            phase <= 1'b1;
            unique case (lw)
                LANE_2:  rx <= {rx[5:0], io_i[1:0]};
                LANE_4:  rx <= {rx[3:0], io_i[3:0]};
                default: rx <= {rx[6:0], io_i[1]};
            endcase
        end else begin
            phase <= 1'b0;
            sh    <= {sh[6:0], 1'b0};
            if (cnt == 3'd0) active <= 1'b0;
            else             cnt    <= cnt - 3'd1;
        end
    end
endmodule

// File: rtl/mfr_read_engine.sv
module mfr_read_engine
    import mfr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmpl_wr,
    input  logic [31:0]       tmpl_wdata,
    input  logic              rst_wr,
    input  logic              dual_sel,
    input  logic              win_req,
    input  logic [ADDR_W-1:0] win_addr,
    output logic              win_ready,
    output logic              win_err,
    output logic [BUS_W-1:0]  win_rdata,
    output logic              stat_init,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic [3:0]        spi_io_o,
    output logic [3:0]        spi_io_oe,
    input  logic [3:0]        spi_io_i
);
    localparam int BYTES = BUS_W / 8;
    localparam int CNT_W = ($clog2(BYTES) > 3) ? $clog2(BYTES) : 3;

    st_t              state;
    tmpl_t            tmpl;
    tmpl_t            snap;
    logic [1:0]       lanes_q;
    logic [31:0]      addr_q;
    logic [BUS_W-1:0] data_q;
    logic             err_q;
    logic [CNT_W-1:0] bcnt;

    logic       go;
    logic [1:0] lw;
    logic [7:0] tx;
    logic       tx_bit;
    logic [7:0] rx;
    logic       done;

    mfr_tmpl u_tmpl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmpl_wr    (tmpl_wr),
        .tmpl_wdata (tmpl_wdata),
        .rst_wr     (rst_wr),
        .tmpl       (tmpl),
        .init       (stat_init)
    );

    mfr_shift u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .lw     (lw),
        .tx     (tx),
        .io_i   (spi_io_i),
        .sck    (spi_sck),
        .tx_bit (tx_bit),
        .rx     (rx),
        .done   (done)
    );

    // State register and per-transaction data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            snap    <= '0;
            lanes_q <= LANE_1;
            addr_q  <= '0;
            data_q  <= '0;
            err_q   <= 1'b0;
            bcnt    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (win_req) begin
                    if (!stat_init) begin
                        err_q <= 1'b1;
                        state <= ST_RESP;
                    end else begin
                        err_q   <= 1'b0;
                        snap    <= tmpl;
                        lanes_q <= (tmpl.field == 2'd1) ? (dual_sel ? LANE_2 : LANE_4) : LANE_1;
                        addr_q  <= 32'(win_addr);
                        state   <= ST_OPCODE;
                    end
                end
                ST_OPCODE: if (done) begin
                    bcnt  <= CNT_W'(snap.frame - 3'd2);
                    state <= ST_ADDR;
                end
                ST_ADDR: if (done) begin
                    if (bcnt != '0) begin
                        bcnt <= bcnt - 1'b1;
                    end else if (snap.inter != 3'd0) begin
                        bcnt  <= CNT_W'(snap.inter - 3'd1);
                        state <= ST_DUMMY;
                    end else begin
                        bcnt  <= '0;
                        state <= ST_DATA;
                    end
                end
                ST_DUMMY: if (done) begin
                    if (bcnt != '0) begin
                        bcnt <= bcnt - 1'b1;
                    end else begin
                        bcnt  <= '0;
                        state <= ST_DATA;
                    end
                end
                ST_DATA: if (done) begin
                    data_q[bcnt*8 +: 8] <= rx;
                    if (bcnt == CNT_W'(BYTES - 1)) state <= ST_RESP;
                    else                           bcnt  <= bcnt + 1'b1;
                end
                ST_RESP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        go        = 1'b0;
        lw        = LANE_1;
        tx        = 8'h00;
        spi_cs_n  = 1'b1;
        spi_io_oe = 4'b0000;
        win_ready = 1'b0;
        win_err   = 1'b0;
        win_rdata = '0;
        unique case (state)
            ST_IDLE: ;
            ST_OPCODE: begin
                go = 1'b1; spi_cs_n = 1'b0; spi_io_oe = 4'b0001;
                tx = snap.opcode;
            end
            ST_ADDR: begin
                go = 1'b1; spi_cs_n = 1'b0; spi_io_oe = 4'b0001;
                tx = addr_q[bcnt*8 +: 8];
            end
            ST_DUMMY: begin
                go = 1'b1; spi_cs_n = 1'b0; spi_io_oe = 4'b0001;
            end
            ST_DATA: begin
                go = 1'b1; spi_cs_n = 1'b0; lw = lanes_q;
            end
            ST_RESP: begin
                win_ready = 1'b1;
                win_err   = err_q;
                win_rdata = err_q ? '0 : data_q;
            end
            default: ;
        endcase
    end

    assign spi_io_o = {3'b000, tx_bit};
endmodule

// File: rtl/mfr_read_engine_chk.sv
module mfr_read_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tmpl_wr,
    input logic [31:0] tmpl_wdata,
    input logic        rst_wr,
    input logic        win_req,
    input logic        win_ready,
    input logic        win_err,
    input logic        stat_init,
    input logic        spi_sck,
    input logic        spi_cs_n,
    input logic [3:0]  spi_io_oe
);
    logic good_frame;
    assign good_frame = (tmpl_wdata[23:21] >= 3'd2) && (tmpl_wdata[23:21] <= 3'd5);

    a_r1_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (tmpl_wr && !rst_wr && good_frame) |=> stat_init);

    a_r3_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (tmpl_wr && !rst_wr && !good_frame && !stat_init) |=> !stat_init);

    a_r4_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        rst_wr |=> !stat_init);

    a_r5_err_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (win_req && !stat_init && spi_cs_n && !win_ready) |=> (win_ready && win_err));

    a_r5_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        win_err |-> (win_ready && spi_cs_n));

    a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        win_ready |=> !win_ready);

    a_r10_cs_done: assert property (@(posedge clk) disable iff (!rst_n)
        win_ready |-> spi_cs_n);

    a_r11_one_lane_out: assert property (@(posedge clk) disable iff (!rst_n)
        spi_io_oe[3:1] == 3'b000);
endmodule

bind mfr_read_engine mfr_read_engine_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmpl_wr    (tmpl_wr),
    .tmpl_wdata (tmpl_wdata),
    .rst_wr     (rst_wr),
    .win_req    (win_req),
    .win_ready  (win_ready),
    .win_err    (win_err),
    .stat_init  (stat_init),
    .spi_sck    (spi_sck),
    .spi_cs_n   (spi_cs_n),
    .spi_io_oe  (spi_io_oe)
);

// File: tb/mfr_read_engine_tb_top.sv
module mfr_read_engine_tb_top;
    localparam int ADDR_W = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tmpl_wr = 1'b0;
    logic [31:0]       tmpl_wdata = '0;
    logic              rst_wr = 1'b0;
    logic              dual_sel = 1'b0;
    logic              win_req = 1'b0;
    logic [ADDR_W-1:0] win_addr = '0;
    logic              win_ready, win_err, stat_init, spi_sck, spi_cs_n;
    logic [31:0]       win_rdata;
    logic [3:0]        spi_io_o, spi_io_oe;
    logic [3:0]        io_drv = 4'h0;

    always #4 clk = ~clk;

    mfr_read_engine #(.ADDR_W(ADDR_W), .BUS_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .tmpl_wr(tmpl_wr), .tmpl_wdata(tmpl_wdata),
        .rst_wr(rst_wr), .dual_sel(dual_sel), .win_req(win_req), .win_addr(win_addr),
        .win_ready(win_ready), .win_err(win_err), .win_rdata(win_rdata),
        .stat_init(stat_init), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_io_o(spi_io_o), .spi_io_oe(spi_io_oe), .spi_io_i(io_drv)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fmem(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // ---------------- flash model ----------------
    int          m_abytes = 3, m_dummy = 0, m_lanes = 1;
    int          rises = 0, dbit = 0, oe_bad = 0;
    logic [7:0]  m_op = '0, m_byte;
    logic [31:0] m_addr = '0;
    int          m_pos;

    always @(negedge spi_cs_n) begin
        rises  = 0; dbit = 0; m_op = '0; m_addr = '0; io_drv = 4'h0;
    end

    always @(posedge spi_sck) begin
        if (rises < 8)                   m_op   = {m_op[6:0], spi_io_o[0]};
        else if (rises < 8 + 8*m_abytes) m_addr = {m_addr[30:0], spi_io_o[0]};
        rises++;
    end

    always @(negedge spi_sck) begin
        if (rises >= 8 + 8*(m_abytes + m_dummy)) begin
            m_byte = fmem(m_addr + 32'(dbit / 8));
            m_pos  = 7 - (dbit % 8);
            io_drv = 4'h0;
            if (m_lanes == 1) io_drv[1] = m_byte[m_pos];
            else for (int k = 0; k < m_lanes; k++) io_drv[k] = m_byte[m_pos - (m_lanes - 1) + k];
            dbit += m_lanes;
        end
    end

    // R11 lane-direction monitor
    always @(negedge clk) begin
        if (rst_n && !spi_cs_n && spi_sck) begin
            if (rises > 8 + 8*(m_abytes + m_dummy)) begin
                if (spi_io_oe != 4'b0000) oe_bad++;
            end else if (spi_io_oe != 4'b0001) oe_bad++;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [31:0] data;
        logic        err;
        logic [7:0]  op;
        logic [31:0] addr;
        int          edges;
    } exp_t;
    exp_t sb_q[$];

    bit          cur_init = 0;
    logic [7:0]  cur_op = '0;
    int          cur_ab = 1, cur_dum = 0, cur_lanes = 1;

    always @(negedge clk) begin
        if (rst_n && win_ready) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R10", "unexpected response", 32'(win_ready), 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(win_err == e.err, "R5", "error flag", 32'(win_err), 32'(e.err));
                if (e.err) begin
                    check(rises == 0, "R5", "sck edges on error", 32'(rises), 0);
                end else begin
                    check(m_op == e.op, "R6", "opcode", 32'(m_op), 32'(e.op));
                    check(m_addr == e.addr, "R7", "address", m_addr, e.addr);
                    check(rises == e.edges, "R8", "sck edge total", 32'(rises), 32'(e.edges));
                    check(win_rdata == e.data, "R9", "data word", win_rdata, e.data);
                    check(spi_cs_n == 1'b1, "R10", "cs at ready", 32'(spi_cs_n), 1);
                    check(oe_bad == 0, "R11", "output enable", 32'(oe_bad), 0);
                end
            end
        end
    end

    task automatic write_tmpl(input logic [7:0] op, input logic [2:0] fr,
                              input logic [1:0] fld, input logic [2:0] inter,
                              input string req);
        bit ok;
        ok = (fr >= 3'd2) && (fr <= 3'd5);
        @(negedge clk);
        tmpl_wdata = {op, fr, fld, inter, 16'h0000};
        tmpl_wr = 1'b1;
        @(negedge clk);
        tmpl_wr = 1'b0;
        if (ok) begin
            cur_init = 1; cur_op = op; cur_ab = int'(fr) - 1; cur_dum = int'(inter);
            cur_lanes = (fld == 2'd1) ? (dual_sel ? 2 : 4) : 1;
        end
        check(stat_init == cur_init, req, "init after template write", 32'(stat_init), 32'(cur_init));
        m_abytes = cur_ab; m_dummy = cur_dum; m_lanes = cur_lanes;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a);
        exp_t e;
        logic [31:0] a32;
        int t;
        a32 = 32'(a);
        e.err = !cur_init;
        e.op  = cur_op;
        e.addr = (cur_ab == 4) ? a32 : (a32 & ((32'd1 << (8*cur_ab)) - 32'd1));
        for (int k = 0; k < 4; k++) e.data[8*k +: 8] = fmem(e.addr + 32'(k));
        e.edges = 8 + 8*cur_ab + 8*cur_dum + 32/cur_lanes;
        sb_q.push_back(e);
        @(negedge clk);
        rises = 0; oe_bad = 0;
        win_addr = a;
        win_req = 1'b1;
        t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (!win_ready && t < 2000);
        win_req = 1'b0;
        if (t >= 2000) check(1'b0, "R10", "read timeout", 0, 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(stat_init == 1'b0, "R1", "init after reset", 32'(stat_init), 0);
        check(spi_cs_n == 1'b1, "R1", "cs after reset", 32'(spi_cs_n), 1);
        check(spi_sck == 1'b0, "R1", "sck after reset", 32'(spi_sck), 0);
        check(win_ready == 1'b0, "R1", "ready after reset", 32'(win_ready), 0);

        do_read(24'h000010);                        // R5 before any template
        write_tmpl(8'h77, 3'd1, 2'd0, 3'd0, "R3");  // rejected frame
        do_read(24'h000020);                        // R5 still uninitialized

        write_tmpl(8'h03, 3'd4, 2'd0, 3'd0, "R2");  // 3 address bytes, serial
        do_read(24'h123456);
        do_read(24'h00FF01);

        write_tmpl(8'h0B, 3'd5, 2'd0, 3'd1, "R2");  // 4 address bytes, 1 dummy byte
        do_read(24'hABCDEF);                        // R7 zero top byte, R8
        write_tmpl(8'hEE, 3'd7, 2'd1, 3'd3, "R3");  // rejected, old template kept
        do_read(24'h5A5A01);

        dual_sel = 1'b1;
        write_tmpl(8'h3B, 3'd4, 2'd1, 3'd1, "R9");  // dual data
        do_read(24'h010203);

        dual_sel = 1'b0;
        write_tmpl(8'h6B, 3'd3, 2'd1, 3'd2, "R9");  // quad data, 2 address bytes
        do_read(24'h12F0E4);                        // R7 truncation

        write_tmpl(8'h13, 3'd2, 2'd2, 3'd0, "R9");  // field 2 means serial, 1 address byte
        do_read(24'h4455AA);

        // R4 reset bit
        @(negedge clk);
        rst_wr = 1'b1;
        @(negedge clk);
        rst_wr = 1'b0;
        cur_init = 0;
        check(stat_init == 1'b0, "R4", "init after reset bit", 32'(stat_init), 0);
        do_read(24'h000100);

        // R4 reset bit wins over a simultaneous template write
        @(negedge clk);
        tmpl_wdata = {8'h03, 3'd4, 2'd0, 3'd0, 16'h0000};
        tmpl_wr = 1'b1;
        rst_wr = 1'b1;
        @(negedge clk);
        tmpl_wr = 1'b0;
        rst_wr = 1'b0;
        check(stat_init == 1'b0, "R4", "reset beats template write", 32'(stat_init), 0);
        do_read(24'h000200);

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R10", "responses outstanding", 32'(sb_q.size()), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule